// File: doc/BRIEF.md
# Systolic 4x4 SAD Array for Full-Search Motion Estimation

This block forms the sum of absolute differences between a stored 16x16 current macroblock and candidate 16x16 windows of a search area, split into sixteen 4x4 sub-blocks. One 8-bit pixel of the macroblock sits in each of 256 processing elements. A controller loads the macroblock one row per cycle. It then feeds the search area one 16-pixel row per cycle. Each search pixel is shared by every element of its column. Each element forms an absolute difference. Groups of four neighbouring elements in a row add their four differences. Those group sums are carried downward through registers, one row per cycle, and restart at every fourth row. Delay lines align the four block rows so that all sixteen 4x4 SADs of one candidate appear together.

Once sixteen search rows have been accepted, every further accepted row yields the next candidate one line lower. A second 16-pixel search port and a per-row port select let the next search column enter the array while the last candidates of the current column are still being summed. The move to a new column therefore costs no idle cycles. A start pulse empties the pipeline before a new run.

Top module: `sad4x4_array`

## Requirements
- R1: While reset is low and after its release, `sad_valid` is 0 and every field of `sad_out` is 0 until results are produced.
- R2: With `ld_en` high, the 16 pixels on `ld_pix` (pixel c at bits [8c+7:8c]) replace macroblock row `ld_row` in one cycle. All other rows keep their contents.
- R3: Result field j of `sad_out` (bits [12j+11:12j], j = 4*blockrow + blockcol) equals the sum, over macroblock rows 4*blockrow..+3 and columns 4*blockcol..+3, of |current pixel - search pixel| for the candidate being reported.
- R4: Counting accepted search rows (cycles with `srch_en` high) from 0 after start or reset, `sad_valid` first rises after the edge that accepts row 15 and reports candidate 0. Each later accepted row k reports candidate k-15. Array row r of candidate v uses the pixels accepted at row v+r.
- R5: While `srch_en` is low, no search row is accepted, `sad_valid` is 0 and `sad_out` holds its value. A run resumes with no candidate lost.
- R6: A start pulse clears all partial sums and the row count. It takes priority over `srch_en` in the same cycle, and that cycle's search row is dropped. `sad_valid` stays 0 until 16 new rows are accepted.
- R7: In each accepted cycle, array row r takes its search pixels from `srch_b` when `row_sel[r]` is 1 and from `srch_a` when it is 0.
- R8: If `row_sel[r]` is set for exactly the rows r <= k-T at accepted row k, with the new column's row j on `srch_b` at accepted row T+j, then the last candidate of the old column and the first of the new column come out on consecutive accepted cycles.
- R9: Each field reaches the full value 4080 (16 x 255) without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Clears pipeline state and row count |
| ld_en | input | 1 | Macroblock row write enable |
| ld_row | input | 4 | Macroblock row index to write |
| ld_pix | input | 128 | 16 macroblock pixels, pixel c at [8c+7:8c] |
| srch_en | input | 1 | A search row is presented this cycle |
| srch_a | input | 128 | Search row port A (current column) |
| srch_b | input | 128 | Search row port B (next column) |
| row_sel | input | 16 | Per array row: 1 selects port B |
| sad_valid | output | 1 | `sad_out` holds a new candidate's results |
| sad_out | output | 192 | Sixteen 12-bit 4x4 SADs, field j at [12j+11:12j] |

## Verification
The assertions take for granted that `start` and `srch_en` are known after reset. They also assume the macroblock is not rewritten while a run is in flight, because a rewrite would mix old and new pixels inside one candidate. The stimulus loads the macroblock only while the array is idle and issues a start before each run. It drives every control input at the falling edge from reset onward. Port-select patterns are either random or the row-by-row staircase of a column change. The `srch_b` data is always defined, so the selected pixels are always known.

// File: rtl/sad_pkg.sv
// Package sad_pkg
// Shared default dimensions for the 4x4 SAD array. All widths below are
// derived in the modules from these values; nothing here holds state.
package sad_pkg;
    parameter int PIX_W = 8;   // bits per pixel
    parameter int MB_N  = 16;  // macroblock edge in pixels
    parameter int BLK   = 4;   // sub-block edge in pixels
endpackage

// File: rtl/sad_pe_row.sv
// Module sad_pe_row
// One row of processing elements. Holds one macroblock row (written when
// ld_en is high) and forms, per group of BLK columns, the sum of absolute
// differences against the broadcast search row. Purely combinational on
// the search side; assumes N is a multiple of BLK.
module sad_pe_row #(
    parameter int PIX_W  = 8,
    parameter int N      = 16,
    parameter int BLK    = 4,
    parameter int GSUM_W = PIX_W + $clog2(BLK)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ld_en,
    input  logic [N*PIX_W-1:0]            ld_pix,
    input  logic [N*PIX_W-1:0]            srch_pix,
    output logic [(N/BLK)*GSUM_W-1:0]     grp_sum
);
    localparam int NG = N / BLK;

    logic [N*PIX_W-1:0] cur_q;
    logic [PIX_W-1:0]   ad [N];

    // Store the macroblock row when this row is addressed.
    always_ff @(posedge clk) begin
        if (!rst_n)     cur_q <= '0;
        else if (ld_en) cur_q <= ld_pix;
    end

    // Per-element absolute difference.
    for (genvar c = 0; c < N; c++) begin : g_pe
        assign ad[c] = (cur_q[c*PIX_W +: PIX_W] > srch_pix[c*PIX_W +: PIX_W])
                     ? cur_q[c*PIX_W +: PIX_W] - srch_pix[c*PIX_W +: PIX_W]
                     : srch_pix[c*PIX_W +: PIX_W] - cur_q[c*PIX_W +: PIX_W];
    end

    // Horizontal group sums of BLK differences.
    always_comb begin
        grp_sum = '0;
        for (int g = 0; g < NG; g++) begin
            for (int c = 0; c < BLK; c++) begin
                grp_sum[g*GSUM_W +: GSUM_W] += GSUM_W'(ad[g*BLK + c]);
            end
        end
    end
endmodule

// File: rtl/sad_delay.sv
// Module sad_delay
// Enable-gated shift register of DEPTH stages (DEPTH >= 1) used to align
// block-row results. clr empties it; stages advance only when en is high.
module sad_delay #(
    parameter int W     = 48,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] sh_q [DEPTH];

    // Shift one stage per accepted cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int i = 0; i < DEPTH; i++) sh_q[i] <= '0;
        end else if (en) begin
            sh_q[0] <= din;
            for (int i = 1; i < DEPTH; i++) sh_q[i] <= sh_q[i-1];
        end
    end

    assign dout = sh_q[DEPTH-1];
endmodule

// File: rtl/sad4x4_array.sv
// Module sad4x4_array
// Systolic array producing sixteen 4x4 SADs per accepted search row once
// filled. Search pixels are shared down columns; group sums ripple down the
// rows through registers, restarting every BLK rows; block rows are aligned
// by delay lines. Assumes no macroblock load during a run.
module sad4x4_array
    import sad_pkg::*;
#(
    parameter int P_W = PIX_W,
    parameter int N   = MB_N,
    parameter int B   = BLK,
    localparam int NB     = N / B,
    localparam int ROW_W  = N * P_W,
    localparam int GSUM_W = P_W + $clog2(B),
    localparam int SAD_W  = P_W + $clog2(B*B),
    localparam int OUT_W  = NB * NB * SAD_W,
    localparam int RIDX_W = $clog2(N),
    localparam int CNT_W  = $clog2(N + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ld_en,
    input  logic [RIDX_W-1:0] ld_row,
    input  logic [ROW_W-1:0]  ld_pix,
    input  logic              srch_en,
    input  logic [ROW_W-1:0]  srch_a,
    input  logic [ROW_W-1:0]  srch_b,
    input  logic [N-1:0]      row_sel,
    output logic              sad_valid,
    output logic [OUT_W-1:0]  sad_out
);
    logic                    adv;
    logic [NB*GSUM_W-1:0]    grp_w [N];
    logic [NB*SAD_W-1:0]     acc_w [N];
    logic [NB*SAD_W-1:0]     blk_w [NB];
    logic [CNT_W-1:0]        cnt_q;
    logic                    valid_q;

    assign adv = srch_en && !start;

    for (genvar r = 0; r < N; r++) begin : g_row
        logic [ROW_W-1:0]     pix_w;
        logic [NB*SAD_W-1:0]  acc_q;

        assign pix_w = row_sel[r] ? srch_b : srch_a;

        sad_pe_row #(.PIX_W(P_W), .N(N), .BLK(B), .GSUM_W(GSUM_W)) u_pe_row (
            .clk      (clk),
            .rst_n    (rst_n),
            .ld_en    (ld_en && (ld_row == RIDX_W'(r))),
            .ld_pix   (ld_pix),
            .srch_pix (pix_w),
            .grp_sum  (grp_w[r])
        );

        // Accumulate the group sum onto the partial result from the row above.
        always_ff @(posedge clk) begin
            if (!rst_n || start) begin
                acc_q <= '0;
            end else if (adv) begin
                for (int g = 0; g < NB; g++) begin
                    if (r % B == 0)
                        acc_q[g*SAD_W +: SAD_W] <= SAD_W'(grp_w[r][g*GSUM_W +: GSUM_W]);
                    else
                        acc_q[g*SAD_W +: SAD_W] <= acc_w[(r == 0) ? 0 : r-1][g*SAD_W +: SAD_W]
                                                 + SAD_W'(grp_w[r][g*GSUM_W +: GSUM_W]);
                end
            end
        end

        assign acc_w[r] = acc_q;
    end

    for (genvar br = 0; br < NB; br++) begin : g_align
        if (br == NB - 1) begin : g_last
            assign blk_w[br] = acc_w[br*B + B - 1];
        end else begin : g_dly
            sad_delay #(.W(NB*SAD_W), .DEPTH((NB - 1 - br) * B)) u_dly (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (start),
                .en    (adv),
                .din   (acc_w[br*B + B - 1]),
                .dout  (blk_w[br])
            );
        end
        assign sad_out[br*NB*SAD_W +: NB*SAD_W] = blk_w[br];
    end

    // Count accepted rows and flag results once N rows of a candidate are in.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            cnt_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= srch_en && (cnt_q >= CNT_W'(N - 1));
            if (srch_en && cnt_q != CNT_W'(N)) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign sad_valid = valid_q;
endmodule

// File: rtl/sad4x4_array_chk.sv
// Module sad4x4_array_chk
// Property checker for sad4x4_array, attached by bind. Keeps its own count
// of accepted search rows to check the fill latency.
module sad4x4_array_chk #(
    parameter int N     = 16,
    parameter int SAD_W = 12,
    parameter int NS    = 16,
    parameter int MAXV  = 4080
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                srch_en,
    input logic                sad_valid,
    input logic [NS*SAD_W-1:0] sad_out
);
    int beats_q;

    // Independent count of accepted rows since start or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || start)            beats_q <= 0;
        else if (srch_en && beats_q < N) beats_q <= beats_q + 1;
    end

    assert_start_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !sad_valid);

    assert_idle_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !srch_en) |=> (!sad_valid && $stable(sad_out)));

    assert_fill_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sad_valid |-> (beats_q >= N));

    assert_valid_follows_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sad_valid |-> $past(srch_en));

    // Every reported field stays within the full-scale value (R9).
    always_ff @(posedge clk) begin
        if (rst_n && sad_valid) begin
            for (int j = 0; j < NS; j++) begin
                assert_no_overflow_R9: assert (sad_out[j*SAD_W +: SAD_W] <= SAD_W'(MAXV));
            end
        end
    end
endmodule

bind sad4x4_array sad4x4_array_chk #(.N(N), .SAD_W(SAD_W), .NS(NB*NB),
                                     .MAXV(N*N/NB/NB*((1 << P_W) - 1))) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .srch_en   (srch_en),
    .sad_valid (sad_valid),
    .sad_out   (sad_out)
);

// File: tb/sad4x4_array_bench.sv
// Scoreboard bench for sad4x4_array: the driver task records the pixels each
// array row sees and queues expected results; a monitor pops and compares.
module sad4x4_array_bench;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         ld_en = 1'b0;
    logic [3:0]   ld_row = '0;
    logic [127:0] ld_pix = '0;
    logic         srch_en = 1'b0;
    logic [127:0] srch_a = '0;
    logic [127:0] srch_b = '0;
    logic [15:0]  row_sel = '0;
    logic         sad_valid;
    logic [191:0] sad_out;

    int total = 0;
    int bad = 0;
    int k = 0;
    int nvalid = 0;
    bit finished = 0;

    logic [7:0]   cur  [16][16];
    logic [7:0]   hist [16][16][16];
    logic [191:0] exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sad4x4_array u_sad4x4_array (
        .clk(clk), .rst_n(rst_n), .start(start), .ld_en(ld_en), .ld_row(ld_row),
        .ld_pix(ld_pix), .srch_en(srch_en), .srch_a(srch_a), .srch_b(srch_b),
        .row_sel(row_sel), .sad_valid(sad_valid), .sad_out(sad_out)
    );

    task automatic check(input string tag, input logic [191:0] act, input logic [191:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Expected result for candidate v from recorded per-row pixels (R3).
    function automatic logic [191:0] model(input int v);
        logic [191:0] res = '0;
        for (int j = 0; j < 16; j++) begin
            int s = 0;
            for (int r = 0; r < 4; r++) begin
                for (int c = 0; c < 4; c++) begin
                    int rr = 4*(j/4) + r;
                    int cc = 4*(j%4) + c;
                    int p = hist[(v + rr) % 16][rr][cc];
                    int q = cur[rr][cc];
                    s += (p > q) ? p - q : q - p;
                end
            end
            res[j*12 +: 12] = 12'(s);
        end
        return res;
    endfunction

    task automatic load_row(input int r, input logic [127:0] pix);
        ld_en = 1'b1; ld_row = 4'(r); ld_pix = pix;
        for (int c = 0; c < 16; c++) cur[r][c] = pix[8*c +: 8];
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic beat(input logic [127:0] a, input logic [127:0] b, input logic [15:0] s);
        srch_en = 1'b1; srch_a = a; srch_b = b; row_sel = s;
        for (int r = 0; r < 16; r++)
            for (int c = 0; c < 16; c++)
                hist[k % 16][r][c] = s[r] ? b[8*c +: 8] : a[8*c +: 8];
        if (k >= 15) exp_q.push_back(model(k - 15));
        k++;
        @(negedge clk);
        srch_en = 1'b0;
    endtask

    task automatic idle();
        srch_en = 1'b0;
        @(negedge clk);
    endtask

    // Start pulse; srch_en held high in the same cycle to show it is dropped (R6).
    task automatic go();
        start = 1'b1; srch_en = 1'b1; srch_a = {16{8'hff}};
        @(negedge clk);
        start = 1'b0; srch_en = 1'b0;
        k = 0;
    endtask

    function automatic logic [127:0] rnd_row();
        logic [127:0] x;
        for (int i = 0; i < 4; i++) x[32*i +: 32] = $urandom;
        return x;
    endfunction

    function automatic logic [127:0] cur_row(input int r);
        logic [127:0] x;
        for (int c = 0; c < 16; c++) x[8*c +: 8] = cur[r][c];
        return x;
    endfunction

    // Monitor: compare each produced result with the queued expectation.
    always @(negedge clk) begin
        if (rst_n && sad_valid && !finished) begin
            nvalid++;
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R4 unexpected valid actual=1 expected=0");
            end else begin
                check("R3 scoreboard", sad_out, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [191:0] held;
        logic [127:0] wa [23];
        logic [127:0] wb [23];
        int v0;

        repeat (3) @(negedge clk);
        check("R1 reset valid", 192'(sad_valid), 192'(0));
        check("R1 reset sad", sad_out, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset valid", 192'(sad_valid), 192'(0));
        check("R1 after reset sad", sad_out, '0);

        // R2: load macroblock rows.
        for (int r = 0; r < 16; r++) load_row(r, rnd_row());

        // R4 + R6: fill latency; start cycle with srch_en high is dropped.
        go();
        for (int i = 0; i < 15; i++) begin
            beat(rnd_row(), rnd_row(), 16'h0000);
            check("R4 no valid during fill", 192'(sad_valid), 192'(0));
        end
        beat(rnd_row(), rnd_row(), 16'h0000);
        check("R4 first valid after 16 rows", 192'(sad_valid), 192'(1));
        for (int i = 0; i < 6; i++) beat(rnd_row(), rnd_row(), 16'h0000);

        // R5: hold while srch_en low, then resume without losing candidates.
        held = sad_out;
        for (int i = 0; i < 3; i++) begin
            idle();
            check("R5 idle valid low", 192'(sad_valid), 192'(0));
            check("R5 idle sad held", sad_out, held);
        end
        for (int i = 0; i < 5; i++) beat(rnd_row(), rnd_row(), 16'h0000);

        // R6: restart mid-stream; nothing reported until 16 new rows.
        go();
        v0 = nvalid;
        for (int i = 0; i < 15; i++) beat(rnd_row(), rnd_row(), 16'h0000);
        check("R6 no valid after restart", 192'(nvalid - v0), 192'(0));
        beat(rnd_row(), rnd_row(), 16'h0000);
        idle();

        // R2: rewrite one row while idle; the others stay (scoreboard checks).
        load_row(5, rnd_row());
        go();
        for (int i = 0; i < 20; i++) beat(rnd_row(), rnd_row(), 16'h0000);
        idle();

        // R7: random per-row port selection.
        go();
        for (int i = 0; i < 24; i++) beat(rnd_row(), rnd_row(), 16'($urandom));
        idle();

        // R8: column change with staircase select; 8 old + 8 new candidates.
        for (int j = 0; j < 23; j++) begin
            wa[j] = rnd_row();
            wb[j] = (j < 16) ? cur_row(j) : rnd_row();
        end
        go();
        v0 = nvalid;
        for (int i = 0; i < 31; i++) begin
            logic [15:0] s = '0;
            for (int r = 0; r < 16; r++) s[r] = (i - 8 >= r);
            beat((i < 23) ? wa[i] : rnd_row(), (i >= 8) ? wb[i - 8] : rnd_row(), s);
            if (i == 23) check("R8 new column candidate matches", sad_out, '0);
        end
        idle();
        check("R8 no bubble: 16 results", 192'(nvalid - v0), 192'(16));

        // R3: exact match gives zero in every field.
        go();
        for (int i = 0; i < 16; i++) beat(cur_row(i), rnd_row(), 16'h0000);
        check("R3 exact match zero", sad_out, '0);
        idle();

        // R9: full-scale difference.
        for (int r = 0; r < 16; r++) load_row(r, '0);
        go();
        for (int i = 0; i < 16; i++) beat({16{8'hff}}, '0, 16'h0000);
        check("R9 full scale", sad_out, {16{12'd4080}});
        idle();
        idle();

        check("R3 all expected produced", 192'(exp_q.size()), 192'(0));
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule